// File: doc/BRIEF.md
# Serial Transmit Path with Buffered Holding Stage

This block is the outgoing half of a 16550-style asynchronous serial channel. A host pushes bytes in through a holding write port. With the buffer mode on, the bytes queue in a 32-entry first-in first-out store. With it off, the store behaves as a single-byte holding register. When the shifter is idle it takes the oldest byte and sends one character on the line. The character is a low start bit, then 5 to 8 data bits with the least significant first, then an optional parity bit, then one or two high stop bits.

The line is paced by an oversampling tick from an external rate generator. Each serial bit lasts 16, 8 or 4 ticks, depending on a 2-bit field. Two status flags show whether the holding stage is drained and whether the whole path is drained. A transmit-empty interrupt request is raised when enabled. In single-byte mode the trigger is the holding register emptying. In buffer mode the trigger is the fill level dropping below a chosen threshold. The request is dropped by a holding write or by a status-read acknowledge.

Top module: `sertx_top`

## Requirements
- R1: Every character begins with one low start bit, followed by the data bits least significant first, then the parity bit when `par_en` is 1, then the stop bits (high). `data_len` 00,01,10,11 selects 5,6,7,8 data bits. `stop2`=1 gives two stop bits.
- R2: Every serial bit lasts exactly N `os_tick` pulses. `os_mode` 01 gives N=8 and 10 gives N=4. Both 00 and 11 give N=16. Cycles without a tick do not advance the line.
- R3: The parity bit is chosen by `par_mode`. 00 makes the count of ones over data and parity odd. 01 makes that count even. 10 sends a constant 1. 11 sends a constant 0.
- R4: With `fifo_en`=1, up to 32 bytes wait in the buffer and are sent in write order. A write while the buffer is full is dropped and never transmitted.
- R5: With `fifo_en`=0, the holding stage stores a single byte. A write while that byte is still waiting is dropped.
- R6: `hold_empty` is 1 exactly when no byte waits in the holding stage or buffer. A byte that has moved into the shifter no longer counts.
- R7: `shift_empty` is 1 only when the shifter is idle and `hold_empty` is 1.
- R8: With `fifo_en`=1 and `int_en`=1, `tx_irq` rises when the buffer level falls from at least T to below T. `trig_sel` 00,01,10,11 gives T=8,16,24,30. `tx_irq` also rises when `int_en` turns on while the level is below T. `tx_irq` is 0 whenever `int_en` was 0 on the previous clock.
- R9: With `fifo_en`=0 and `int_en`=1, `tx_irq` rises when the holding byte moves into the shifter.
- R10: A holding write or an `irq_ack` pulse clears `tx_irq` on the next clock.
- R11: A `fifo_clr` pulse discards every waiting byte and sets `hold_empty`. The character already in the shifter still completes.
- R12: After reset, `txd` is high, both empty flags are 1 and `tx_irq` is 0. `txd` stays high whenever no character is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversampling tick, one clock wide |
| os_mode | input | 2 | Ticks per bit select |
| fifo_en | input | 1 | 1 = 32-byte buffer, 0 = single holding byte |
| data_len | input | 2 | Data bits per character (5..8) |
| par_en | input | 1 | Insert parity bit |
| par_mode | input | 2 | Parity kind |
| stop2 | input | 1 | Two stop bits |
| trig_sel | input | 2 | Buffer interrupt threshold select |
| int_en | input | 1 | Transmit-empty interrupt enable |
| wr_en | input | 1 | Holding write strobe |
| wr_data | input | 8 | Byte to send |
| fifo_clr | input | 1 | Discard buffered bytes |
| irq_ack | input | 1 | Status read acknowledging the transmit-empty source |
| txd | output | 1 | Serial line, idle high |
| hold_empty | output | 1 | Holding stage drained |
| shift_empty | output | 1 | Holding stage and shifter drained |
| tx_irq | output | 1 | Transmit-empty interrupt request |

## Verification
The hardest case to reach is an exact threshold crossing of the buffer level. A running shifter drains the buffer steadily, so a sampled level is hard to pin down. The bench therefore stops the tick, so a burst of writes leaves a known count waiting. It then pulses the clear, which drops the level to zero in one step. Placing the count one below and exactly at each of the four thresholds shows whether the request is raised. The same stalled-tick method holds a byte in the shifter, so the dropped write to a full buffer or single holding register can be seen on the line.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int OS_MAX = 16;
  localparam int OS_CW  = $clog2(OS_MAX);

  typedef enum logic [1:0] {
    PAR_ODD  = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_MARK = 2'b10,
    PAR_SPACE = 2'b11
  } par_kind_e;

  // last tick index of a bit period for the chosen oversampling
  function automatic logic [OS_CW-1:0] os_limit(input logic [1:0] m);
    case (m)
      2'b01:   return OS_CW'(OS_MAX / 2 - 1);
      2'b10:   return OS_CW'(OS_MAX / 4 - 1);
      default: return OS_CW'(OS_MAX - 1);
    endcase
  endfunction
endpackage

// File: rtl/sertx_fifo.sv
module sertx_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          fifo_mode,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  input  logic          rd,
  output logic [W-1:0]  rdata,
  output logic          empty,
  output logic          full,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt_nx;
  logic          wr_ok, rd_ok;

  assign full  = fifo_mode ? (count >= CW'(DEPTH)) : (count != '0);
  assign wr_ok = wr && !full;
  assign rd_ok = rd && (count != '0);
  assign cnt_nx = count + CW'(wr_ok) - CW'(rd_ok);
  assign rdata = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_ok && !clr) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
      empty <= 1'b1;
    end else begin
      if (wr_ok) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (rd_ok) rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      count <= cnt_nx;
      empty <= (cnt_nx == '0);
    end
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int FRAME_W = DATA_W + 4,
  localparam int BC_W = $clog2(FRAME_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic [1:0]        os_mode,
  input  logic [1:0]        data_len,
  input  logic              par_en,
  input  logic [1:0]        par_mode,
  input  logic              stop2,
  input  logic              avail,
  input  logic [DATA_W-1:0] din,
  output logic              pop,
  output logic              busy,
  output logic              txd
);
  logic [FRAME_W-1:0] sreg, frame;
  logic [DATA_W-1:0]  dm;
  logic [BC_W-1:0]    left, nbits;
  logic [OS_CW-1:0]   tcnt, lim;
  logic               par;
  int                 len;

  always_comb begin
    len = int'(data_len) + DATA_W - 3;
    dm  = '0;
    for (int i = 0; i < DATA_W; i++) if (i < len) dm[i] = din[i];
    case (par_mode)
      PAR_ODD:  par = ~^dm;
      PAR_EVEN: par = ^dm;
      PAR_MARK: par = 1'b1;
      default:  par = 1'b0;
    endcase
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 1; i < FRAME_W; i++) begin
      if (i <= len) frame[i] = dm[(i - 1) % DATA_W];
      else if (par_en && i == len + 1) frame[i] = par;
    end
    nbits = BC_W'(len + 2 + int'(par_en) + int'(stop2));
  end

  assign pop = !busy && avail;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      sreg <= '1;
      left <= '0;
      tcnt <= '0;
      lim  <= '0;
      txd  <= 1'b1;
    end else if (!busy) begin
      if (avail) begin
        busy <= 1'b1;
        sreg <= frame;
        txd  <= frame[0];
        left <= nbits;
        tcnt <= '0;
        lim  <= os_limit(os_mode);
      end
    end else if (os_tick) begin
      if (tcnt == lim) begin
        tcnt <= '0;
        if (left == BC_W'(1)) begin
          busy <= 1'b0;
          sreg <= '1;
          txd  <= 1'b1;
        end else begin
          sreg <= {1'b1, sreg[FRAME_W-1:1]};
          txd  <= sreg[1];
          left <= left - 1'b1;
        end
      end else begin
        tcnt <= tcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sertx_irq.sv
module sertx_irq #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_mode,
  input  logic          int_en,
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] level,
  input  logic          hold_empty,
  input  logic          host_wr,
  input  logic          ack,
  output logic          irq
);
  logic [CW-1:0] trig;
  logic          cond, cond_q, en_q;

  always_comb begin
    case (trig_sel)
      2'b00:   trig = CW'(DEPTH / 4);
      2'b01:   trig = CW'(DEPTH / 2);
      2'b10:   trig = CW'(3 * DEPTH / 4);
      default: trig = CW'(DEPTH - 2);
    endcase
    cond = fifo_mode ? (level < trig) : hold_empty;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cond_q <= 1'b1;
      en_q   <= 1'b0;
      irq    <= 1'b0;
    end else begin
      cond_q <= cond;
      en_q   <= int_en;
      if (!int_en || host_wr || ack) irq <= 1'b0;
      else if (cond && (!cond_q || !en_q)) irq <= 1'b1;
    end
  end
endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              os_tick,
  input  logic [1:0]        os_mode,
  input  logic              fifo_en,
  input  logic [1:0]        data_len,
  input  logic              par_en,
  input  logic [1:0]        par_mode,
  input  logic              stop2,
  input  logic [1:0]        trig_sel,
  input  logic              int_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              fifo_clr,
  input  logic              irq_ack,
  output logic              txd,
  output logic              hold_empty,
  output logic              shift_empty,
  output logic              tx_irq
);
  logic [DATA_W-1:0] q_data;
  logic [CW-1:0]     q_cnt;
  logic              q_full, q_pop, sh_busy;

  sertx_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_fifo (
    .clk(clk), .rst(rst), .clr(fifo_clr), .fifo_mode(fifo_en),
    .wr(wr_en), .wdata(wr_data), .rd(q_pop), .rdata(q_data),
    .empty(hold_empty), .full(q_full), .count(q_cnt)
  );

  sertx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst(rst), .os_tick(os_tick), .os_mode(os_mode),
    .data_len(data_len), .par_en(par_en), .par_mode(par_mode),
    .stop2(stop2), .avail(!hold_empty), .din(q_data),
    .pop(q_pop), .busy(sh_busy), .txd(txd)
  );

  sertx_irq #(.DEPTH(DEPTH)) u_irq (
    .clk(clk), .rst(rst), .fifo_mode(fifo_en), .int_en(int_en),
    .trig_sel(trig_sel), .level(q_cnt), .hold_empty(hold_empty),
    .host_wr(wr_en), .ack(irq_ack), .irq(tx_irq)
  );

  assign shift_empty = hold_empty && !sh_busy;
endmodule

// File: rtl/sertx_chk.sv
module sertx_chk #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic          int_en,
  input logic          fifo_clr,
  input logic          full,
  input logic [CW-1:0] count,
  input logic          busy,
  input logic          txd,
  input logic          hold_empty,
  input logic          shift_empty,
  input logic          tx_irq
);
  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !txd);                                          // R1
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);                                                 // R12
  AST_FULL_DROP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !fifo_clr) |=> (count <= $past(count)));      // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));                                           // R4
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    fifo_clr |=> hold_empty);                                       // R11
  AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
    shift_empty |-> hold_empty);                                    // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    !int_en |=> !tx_irq);                                           // R8
  AST_WR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !tx_irq);                                             // R10
endmodule

bind sertx_top sertx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .int_en(int_en),
  .fifo_clr(fifo_clr), .full(q_full), .count(q_cnt), .busy(sh_busy),
  .txd(txd), .hold_empty(hold_empty), .shift_empty(shift_empty),
  .tx_irq(tx_irq)
);

// File: tb/tb_sertx_top.sv
module tb_sertx_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic tick_en = 1'b1, tick_half = 1'b0, phase = 1'b0;
  logic os_tick;
  always @(negedge clk) phase <= ~phase;
  assign os_tick = tick_en & (tick_half ? phase : 1'b1);

  logic [1:0] os_mode = 2'b00, data_len = 2'b11, par_mode = 2'b00, trig_sel = 2'b00;
  logic fifo_en = 1'b1, par_en = 1'b0, stop2 = 1'b0, int_en = 1'b0;
  logic wr_en = 1'b0, fifo_clr = 1'b0, irq_ack = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic txd, hold_empty, shift_empty, tx_irq;

  sertx_top dut (
    .clk(clk), .rst(rst), .os_tick(os_tick), .os_mode(os_mode),
    .fifo_en(fifo_en), .data_len(data_len), .par_en(par_en),
    .par_mode(par_mode), .stop2(stop2), .trig_sel(trig_sel),
    .int_en(int_en), .wr_en(wr_en), .wr_data(wr_data),
    .fifo_clr(fifo_clr), .irq_ack(irq_ack), .txd(txd),
    .hold_empty(hold_empty), .shift_empty(shift_empty), .tx_irq(tx_irq)
  );

  int nchk = 0, nfail = 0, cyc = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      nfail = nfail + 1;
      nchk  = nchk + 1;
      $display("FAIL watchdog: act=%0d cycles exp<150000", cyc);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] b);
    wr_data = b; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_clr();
    fifo_clr = 1'b1; @(negedge clk); fifo_clr = 1'b0;
  endtask

  task automatic pulse_ack();
    irq_ack = 1'b1; @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic wait_idle();
    int t = 0;
    while (!shift_empty && t < 5000) begin @(negedge clk); t++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic recv(input int div, input int nb, output logic [11:0] bits);
    int t = 0;
    bits = '1;
    while (txd !== 1'b0 && t < 5000) begin @(negedge clk); t++; end
    if (t >= 5000) begin chk(1'b0, "R1 no start bit", 1, 0); return; end
    repeat (div / 2) @(negedge clk);
    bits[0] = txd;
    for (int i = 1; i < nb; i++) begin
      repeat (div) @(negedge clk);
      bits[i] = txd;
    end
  endtask

  task automatic low_len(output int n);
    int t = 0;
    n = 0;
    while (txd !== 1'b0 && t < 5000) begin @(negedge clk); t++; end
    while (txd === 1'b0 && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic quiet(input int cycles, output bit ok);
    ok = 1'b1;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) ok = 1'b0;
    end
  endtask

  function automatic logic [11:0] exp_frame(input logic [7:0] d, input int len,
      input bit pe, input int pm, input bit s2, output int nb);
    logic [11:0] f = '0;
    int ones = 0, k;
    for (int i = 0; i < len; i++) begin f[1+i] = d[i]; ones += int'(d[i]); end
    k = 1 + len;
    if (pe) begin
      case (pm)
        0: f[k] = (ones % 2) == 0;
        1: f[k] = (ones % 2) == 1;
        2: f[k] = 1'b1;
        default: f[k] = 1'b0;
      endcase
      k++;
    end
    f[k] = 1'b1;
    if (s2) f[k+1] = 1'b1;
    nb = k + 1 + int'(s2);
    return f;
  endfunction

  initial begin
    logic [11:0] got, ex;
    logic [7:0]  d;
    int nb, div, len, n, idx, trig;
    bit ok;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(txd === 1'b1, "R12 reset txd", int'(txd), 1);
    chk(hold_empty === 1'b1, "R12 reset hold_empty", int'(hold_empty), 1);
    chk(shift_empty === 1'b1, "R12 reset shift_empty", int'(shift_empty), 1);
    chk(tx_irq === 1'b0, "R12 reset tx_irq", int'(tx_irq), 0);

    // R1 / R3 sweep over oversampling, length, parity and stop settings
    idx = 0;
    for (int m = 0; m < 3; m++) begin
      div = 16 >> m;
      for (int l = 0; l < 4; l++) begin
        for (int p = 0; p < 5; p++) begin
          for (int s = 0; s < 2; s++) begin
            os_mode = 2'(m); data_len = 2'(l); stop2 = s[0];
            par_en = (p < 4); par_mode = 2'(p);
            len = l + 5;
            d = 8'(idx * 53 + 17);
            ex = exp_frame(d, len, p < 4, p, s[0], nb);
            host_write(d);
            recv(div, nb, got);
            n = int'((got ^ ex) & 12'((1 << nb) - 1));
            chk(n == 0, (p < 4) ? "R3 parity frame" : "R1 frame", int'(got), int'(ex));
            wait_idle();
            chk(txd === 1'b1, "R12 idle high", int'(txd), 1);
            idx++;
          end
        end
      end
    end

    // R2 bit length in ticks
    data_len = 2'b11; par_en = 1'b0; stop2 = 1'b0;
    for (int m = 0; m < 4; m++) begin
      os_mode = 2'(m);
      div = (m == 3) ? 16 : (16 >> m);
      host_write(8'hFF);
      low_len(n);
      chk(n == div, "R2 start length", n, div);
      wait_idle();
    end
    os_mode = 2'b10; tick_half = 1'b1;
    host_write(8'hFF);
    low_len(n);
    chk(n == 7 || n == 8, "R2 half-rate ticks", n, 8);
    wait_idle();
    tick_half = 1'b0;

    // R4 / R6 / R7 buffer depth, order and overflow drop
    fifo_en = 1'b1; os_mode = 2'b10;
    tick_en = 1'b0;
    for (int i = 0; i < 40; i++) begin wr_data = 8'(i + 100); wr_en = 1'b1; @(negedge clk); end
    wr_en = 1'b0;
    @(negedge clk);
    chk(hold_empty === 1'b0, "R6 hold_empty with data", int'(hold_empty), 0);
    chk(shift_empty === 1'b0, "R7 shift_empty with data", int'(shift_empty), 0);
    tick_en = 1'b1;
    for (int k = 0; k < 33; k++) begin
      recv(4, 10, got);
      chk(got[8:1] == 8'(k + 100), "R4 order", int'(got[8:1]), k + 100);
    end
    chk(hold_empty === 1'b1, "R6 drained while shifting", int'(hold_empty), 1);
    chk(shift_empty === 1'b0, "R7 busy shifter", int'(shift_empty), 0);
    repeat (10) @(negedge clk);
    chk(shift_empty === 1'b1, "R7 all drained", int'(shift_empty), 1);
    quiet(100, ok);
    chk(ok, "R4 overflow writes dropped", int'(ok), 1);

    // R8 / R10 / R11 threshold crossing via clear
    int_en = 1'b1;
    for (int t = 0; t < 4; t++) begin
      trig = (t == 3) ? 30 : (t + 1) * 8;
      for (int v = trig - 1; v <= trig; v++) begin
        wait_idle();
        tick_en = 1'b0; trig_sel = 2'(t);
        for (int i = 0; i <= v; i++) begin wr_data = 8'(i); wr_en = 1'b1; @(negedge clk); end
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        chk(tx_irq === 1'b0, "R10 write clears", int'(tx_irq), 0);
        pulse_clr();
        repeat (3) @(negedge clk);
        chk(tx_irq === (v >= trig), "R8 threshold", int'(tx_irq), int'(v >= trig));
        chk(hold_empty === 1'b1, "R11 clear empties", int'(hold_empty), 1);
        if (v >= trig) begin
          pulse_ack();
          @(negedge clk);
          chk(tx_irq === 1'b0, "R10 ack clears", int'(tx_irq), 0);
        end
        tick_en = 1'b1;
        recv(4, 10, got);
        chk(got[8:1] == 8'h00, "R11 shifter byte kept", int'(got[8:1]), 0);
        quiet(60, ok);
        chk(ok, "R11 cleared bytes not sent", int'(ok), 1);
      end
    end
    int_en = 1'b0;
    @(negedge clk);
    chk(tx_irq === 1'b0, "R8 disabled", int'(tx_irq), 0);

    // R5 / R9 single holding byte
    fifo_en = 1'b0; int_en = 1'b1;
    wait_idle();
    pulse_ack();
    tick_en = 1'b0;
    host_write(8'h3C);
    repeat (2) @(negedge clk);
    chk(tx_irq === 1'b1, "R9 irq on move", int'(tx_irq), 1);
    chk(hold_empty === 1'b1, "R6 single moved", int'(hold_empty), 1);
    chk(shift_empty === 1'b0, "R7 single busy", int'(shift_empty), 0);
    host_write(8'hC3);
    chk(hold_empty === 1'b0, "R5 byte held", int'(hold_empty), 0);
    chk(tx_irq === 1'b0, "R10 write clears single", int'(tx_irq), 0);
    host_write(8'h99);
    tick_en = 1'b1;
    recv(4, 10, got);
    chk(got[8:1] == 8'h3C, "R5 first byte", int'(got[8:1]), 'h3C);
    recv(4, 10, got);
    chk(got[8:1] == 8'hC3, "R5 second byte", int'(got[8:1]), 'hC3);
    chk(tx_irq === 1'b1, "R9 irq on second move", int'(tx_irq), 1);
    quiet(80, ok);
    chk(ok, "R5 extra write dropped", int'(ok), 1);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule